// File: doc/BRIEF.md
# Predicated Tree Reduction Scheduler

This block works out the order in which a vector reduction should combine its elements. It uses a pairwise tree, and a predicate mask says which elements take part. It never touches element values. For each combine it emits a pair of element indices. The target element absorbs the other element. A downstream datapath performs the actual operation. When the tree is finished, the block reports which element holds the reduced value.

Masked-out elements are never moved and never filled in. The block keeps a private copy of the mask, called the live set, and a private index-redirection table. When the lower slot of a pair is empty and the upper slot holds a value, the block points the lower slot at the upper element and issues no operation. The schedule depends only on the vector length and the mask, so the same inputs always give the same sequence of pairs.

Levels use a half-distance of 1, 2, 4 and so on, for as long as that distance is below the vector length. Within a level, slot i is visited for every i that is a multiple of twice the half-distance, in ascending order. Each visit takes one cycle. A visit that has an operation waits for `op_ready`.

Top module: `tree_reduce_sched`

## Requirements
- R1: After reset, `op_valid` and `done` are both 0.
- R2: When slot i and slot i+h are both live at level h, the block emits exactly one operation. In that operation `op_target` is the element that slot i refers to and `op_other` is the element that slot i+h refers to. Operations follow ascending h, and within a level they follow ascending i.
- R3: When only the upper slot i+h is live, no operation is emitted. Slot i then refers to the element of slot i+h and becomes live, so later operations name that element.
- R4: A partner slot at or beyond the vector length counts as not live. Mask bits at or above the vector length are ignored. A `vl` value above MAXVL is treated as MAXVL. No emitted index reaches the effective vector length.
- R5: While `op_valid` is 1 and `op_ready` is 0, `op_valid`, `op_target` and `op_other` hold steady into the next cycle. The block advances by one operation per cycle in which both are 1.
- R6: After the last level, `done` is 1 for exactly one cycle. At that time `result_idx` is the lowest-numbered live element below the vector length, and `result_any` shows whether any such element exists. The number of emitted operations is the live count minus one, or zero when no element is live.
- R7: With an effective vector length of 0 or 1, no operation is emitted and `done` rises in the cycle after `start`.
- R8: The mask and length are captured only when `start` is accepted, which happens only while idle. While a reduction runs, asserting `start` or changing `pred_mask` or `vl` has no effect on the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reduction; accepted only when idle |
| vl | input | $clog2(MAXVL)+1 | Vector length, sampled at start |
| pred_mask | input | MAXVL | Predicate mask, sampled at start; bit k enables element k |
| op_valid | output | 1 | An operation pair is offered |
| op_ready | input | 1 | The consumer accepts the offered pair |
| op_target | output | $clog2(MAXVL) | Element that receives the combined value |
| op_other | output | $clog2(MAXVL) | Element that is folded into the target |
| done | output | 1 | One-cycle pulse when the schedule is complete |
| result_idx | output | $clog2(MAXVL) | Element that holds the result; valid with done |
| result_any | output | 1 | At least one element took part; valid with done |

## Verification
The hardest case to reach is a redirection made at one level and then consumed at a later level. This needs an empty lower slot and a live upper slot, followed by a live partner further up. Sparse and alternating masks such as upper-half-only, odd-only and lone high bits, together with odd vector lengths, create this case. The bench then compares every pair against a behavioural model. A restart attempt with a different mask is made in the middle of a run, and ready is randomised so that stalled offers are also checked for stability.

// File: rtl/tree_reduce_sched.sv
module tree_reduce_sched #(
  parameter int MAXVL = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(MAXVL):0]     vl,
  input  logic [MAXVL-1:0]           pred_mask,
  output logic                       op_valid,
  input  logic                       op_ready,
  output logic [$clog2(MAXVL)-1:0]   op_target,
  output logic [$clog2(MAXVL)-1:0]   op_other,
  output logic                       done,
  output logic [$clog2(MAXVL)-1:0]   result_idx,
  output logic                       result_any
);
  localparam int IW = $clog2(MAXVL);
  localparam int CW = IW + 2;

  logic              busy, fin;
  logic [CW-1:0]     half, slot;
  logic [IW:0]       vlq;
  logic [MAXVL-1:0]  live;
  logic [IW-1:0]     idx [MAXVL];

  logic [IW:0]       vl_eff;
  logic [MAXVL:0]    one_hot_len;
  logic [MAXVL-1:0]  len_mask;
  logic [CW-1:0]     vlx, step, pj, next_slot;
  logic [IW-1:0]     si, sj;
  logic              lo_live, hi_live, upper_only, advance;

  assign vl_eff      = (vl > (IW+1)'(MAXVL)) ? (IW+1)'(MAXVL) : vl;
  assign one_hot_len = (MAXVL+1)'(1) << vl_eff;
  assign len_mask    = MAXVL'(one_hot_len - (MAXVL+1)'(1));

  assign vlx        = CW'(vlq);
  assign step       = half << 1;
  assign pj         = slot + half;
  assign next_slot  = slot + step;
  assign si         = slot[IW-1:0];
  assign sj         = pj[IW-1:0];
  assign lo_live    = live[si];
  assign hi_live    = (pj < vlx) && live[sj];
  assign op_valid   = busy && lo_live && hi_live;
  assign upper_only = busy && !lo_live && hi_live;
  assign advance    = busy && (!op_valid || op_ready);

  assign op_target  = idx[si];
  assign op_other   = idx[sj];
  assign done       = fin;
  assign result_idx = idx[0];
  assign result_any = live[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      fin  <= 1'b0;
      half <= '0;
      slot <= '0;
      vlq  <= '0;
      live <= '0;
      for (int k = 0; k < MAXVL; k++) idx[k] <= IW'(k);
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (start) begin
          vlq  <= vl_eff;
          live <= pred_mask & len_mask;
          for (int k = 0; k < MAXVL; k++) idx[k] <= IW'(k);
          half <= CW'(1);
          slot <= '0;
          if (vl_eff > (IW+1)'(1)) busy <= 1'b1;
          else                     fin  <= 1'b1;
        end
      end else if (advance) begin
        if (upper_only) begin
          idx[si]  <= idx[sj];
          live[si] <= 1'b1;
        end
        if (next_slot >= vlx) begin
          slot <= '0;
          if (step >= vlx) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end else begin
            half <= step;
          end
        end else begin
          slot <= next_slot;
        end
      end
    end
  end

  // R2: an operation always pairs a lower element with a higher one
  p_target_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (op_target < op_other));

  // R4: no emitted index reaches the captured length
  p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> ((IW+1)'(op_other) < vlq));

  // R5: a stalled offer holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_target) && $stable(op_other)));

  // R3: live slots never drop out during a run
  p_live_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((live & $past(live)) == $past(live)));

  // R6: done is a single pulse and is raised only from the idle state
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/tree_reduce_sched_bench.sv
module tree_reduce_sched_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] vl = '0;
  logic [N-1:0] pred_mask = '0;
  logic op_valid, op_ready, done, result_any;
  logic [3:0] op_target, op_other, result_idx;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tree_reduce_sched #(.MAXVL(N)) u_tree_reduce_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .pred_mask(pred_mask),
    .op_valid(op_valid), .op_ready(op_ready), .op_target(op_target),
    .op_other(op_other), .done(done), .result_idx(result_idx),
    .result_any(result_any));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int v, input logic [N-1:0] m, input bit poke);
    int vc, first, cyc;
    bit any, got, hold_pend;
    int lv[N];
    int ix[N];
    int qt[$];
    int qo[$];
    int ht, ho;
    vc = (v > N) ? N : v;
    for (int k = 0; k < N; k++) begin
      lv[k] = (k < vc && m[k]) ? 1 : 0;
      ix[k] = k;
    end
    for (int h = 1; h < vc; h = h * 2)
      for (int i = 0; i < vc; i = i + 2 * h) begin
        int j;
        j = i + h;
        if (j < vc) begin
          if (lv[i] != 0 && lv[j] != 0) begin
            qt.push_back(ix[i]);
            qo.push_back(ix[j]);
          end else if (lv[i] == 0 && lv[j] != 0) begin
            ix[i] = ix[j];
            lv[i] = 1;
          end
        end
      end
    first = 0;
    any = 1'b0;
    for (int k = N - 1; k >= 0; k--)
      if (k < vc && m[k]) begin
        first = k;
        any = 1'b1;
      end

    @(posedge clk); #1;
    vl = 5'(v);
    pred_mask = m;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    got = 1'b0;
    hold_pend = 1'b0;
    ht = 0;
    ho = 0;
    while (!got && cyc < 400) begin
      op_ready = ($urandom % 3) != 0;
      if (poke && cyc == 2) begin
        start = 1'b1;
        pred_mask = ~m;
        vl = 5'd9;
      end else begin
        start = 1'b0;
      end
      #1;
      if (hold_pend)
        check(op_valid && op_target == 4'(ht) && op_other == 4'(ho),
              "R5 hold", {op_valid, op_target, op_other}, {1'b1, 4'(ht), 4'(ho)});
      hold_pend = 1'b0;
      if (op_valid) begin
        if (qt.size() == 0) begin
          check(1'b0, "R2 unexpected op", op_target, -1);
        end else if (op_ready) begin
          int et, eo;
          et = qt.pop_front();
          eo = qo.pop_front();
          // R3 R4: redirected and in-range indices come from the model
          check(op_target == 4'(et), "R2 R3 target", op_target, et);
          check(op_other == 4'(eo), "R2 R3 R4 other", op_other, eo);
        end else begin
          hold_pend = 1'b1;
          ht = op_target;
          ho = op_other;
        end
      end
      if (done) begin
        got = 1'b1;
        check(result_any == any, "R6 result_any", result_any, any);
        if (any) check(result_idx == 4'(first), "R6 result_idx", result_idx, first);
        check(qt.size() == 0, "R6 op count", qt.size(), 0);
        if (vc <= 1) check(cyc == 0, "R7 done timing", cyc, 0);
      end
      @(posedge clk); #1;
      cyc++;
    end
    start = 1'b0;
    op_ready = 1'b0;
    if (!got) check(1'b0, "R6 done missing", cyc, 0);
    // R8: no second run may start from the poke
    if (poke) begin
      #1;
      check(!op_valid && !done, "R8 ignored start", {op_valid, done}, 0);
    end
  endtask

  initial begin
    op_ready = 1'b0;
    #9;
    check(!op_valid && !done, "R1 reset outputs", {op_valid, done}, 0);
    rst_n = 1'b1;
    #3;
    check(!op_valid && !done, "R1 idle after reset", {op_valid, done}, 0);
    run(16, 16'hFFFF, 1'b0);
    run(16, 16'h0000, 1'b0);
    run(16, 16'h8000, 1'b0);
    run(16, 16'h0001, 1'b0);
    run(16, 16'hAAAA, 1'b0);   // R3 odd-only
    run(16, 16'h5555, 1'b0);
    run(16, 16'hFF00, 1'b0);   // R3 upper half only
    run(0, 16'hFFFF, 1'b0);    // R7
    run(1, 16'h0001, 1'b0);    // R7
    run(1, 16'h0000, 1'b0);    // R7
    run(5, 16'h001E, 1'b0);
    run(7, 16'h0064, 1'b0);
    run(3, 16'hFFF8, 1'b0);    // R4 mask bits beyond length
    run(31, 16'hFFFF, 1'b0);   // R4 clamp
    run(11, 16'h0540, 1'b0);
    run(16, 16'h3C5A, 1'b1);   // R8 mid-run start and mask change
    for (int t = 0; t < 25; t++) run(int'($urandom % 18), 16'($urandom), 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #150000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule